// File: doc/BRIEF.md
# Prescaled Up-Counter with Sticky Overflow Flag

This block is a general-purpose up-counting timer with a default width of 16 bits. An 8-bit mode control register selects the count rate from eight power-of-two divisions of the system clock, and it holds a count enable, a unit enable and a sticky overflow flag. When the count wraps from its all-ones value to zero, the block raises a one-cycle overflow interrupt pulse. The flag and the pulse are separate: software can read, set or clear the flag, and this never changes the pulse.

A compare register and a two-bit mode register add an optional clear-on-match. When the clear is active, the count returns to zero on the step taken at the compare value instead of moving on. If the compare value is all-ones, the wrap counts as a clear and not as an overflow. The unit enable acts as a master reset. While it is 0, everything except the unit enable bit is held at zero, and it has to be set before any other control bit will take a value.

Software reaches the registers over a simple bus. Every register can take a byte write or a single-bit write, and read data comes back combinationally. The address map is: 0 control, 1 mode, 2 and 3 compare (low and high byte), 4 and 5 count (low and high byte, read-only).

Top module: `tick_timer`

## Requirements
- R1: After rstN is asserted, the control register (address 0), the mode register (address 1) and the count (addresses 4 low, 5 high) read zero and ovfIrq is low.
- R2: Control register bits: 7 overflow flag, 6:4 clock select, 3:2 reserved, 1 count enable, 0 unit enable. With the unit enabled, a byte write stores bits 7, 6:4, 1 and 0. Bits 3:2 ignore writes and always read 0.
- R3: While the unit enable is 0, a write to the control register applies only bit 0. Every other control bit stays 0.
- R4: A write that clears bit 0 resets the count, the overflow flag and all control bits at that same clock edge. The count then stays 0 while the unit is disabled.
- R5: Clock select code k (0 to 7) divides the count rate by 2^k. After the edge of a write that turns counting on from a stopped state, the count n clock edges later is floor(n / 2^k).
- R6: While the count enable (bit 1) is 0, the count does not change.
- R7: A count step from all-ones to zero sets the overflow flag and raises ovfIrq for exactly one cycle. Both show in the cycle after the wrapping edge, and the count reads 0 in that cycle.
- R8: The overflow flag stays 1 until a write puts 0 into bit 7 or the unit enable is cleared.
- R9: When a control write that covers bit 7 lands on the same edge as an overflow, the flag takes the written value.
- R10: Writes to the overflow flag neither create nor cancel an ovfIrq pulse.
- R11: Mode bit 0 selects compare mode and mode bit 1 enables clear-on-match. The other mode bits read 0. The compare value sits at address 2 (low byte) and address 3 (high byte, only CNT_W-8 bits stored). When both mode bits are 1, a count step taken while the count equals the compare value loads 0.
- R12: With clear-on-match active and a compare value of all-ones, the wrap from all-ones to zero is a clear. It sets no flag and raises no ovfIrq.
- R13: A single-bit write (wrBit = 1) changes only bit bitSel of the addressed register, to the value wrData[bitSel].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrBit | input | 1 | Qualifies wrEn as a single-bit write |
| addr | input | 3 | Register address for reads and writes |
| bitSel | input | 3 | Bit position for single-bit writes |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr, combinational |
| ovfIrq | output | 1 | One-cycle overflow interrupt pulse |

## Verification
A write lands on the first rising edge after it is driven. Register read-back and the count are due in the low phase that follows that edge. Since reads are combinational, they add no latency. The count is due exactly n edges after the enabling write, and the bench compares it with floor(n / 2^k) or with n modulo (compare + 1). The flag and ovfIrq are due one edge after the count sits at all-ones, so the bench samples them in the low phase right after that edge and again one cycle later to confirm the pulse has ended. The bench drives every input just after a falling edge and samples shortly afterwards, so each sample falls in a known cycle.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int SEL_W   = 3;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int BIT_OVF = 7;
  localparam int SEL_LSB = 4;
  localparam int RSV_LSB = 2;
  localparam int BIT_CEN = 1;
  localparam int BIT_UEN = 0;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_MODE  = 3'd1,
    A_CMPLO = 3'd2,
    A_CMPHI = 3'd3,
    A_CNTLO = 3'd4,
    A_CNTHI = 3'd5
  } regAddr_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             unitOn;
    logic             unitClr;
    logic             countOn;
    logic [SEL_W-1:0] clkSel;
    logic             clrOnMatch;
  } timerCtl_t;

endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                wrBit,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [SEL_W-1:0]    bitSel,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic [CNT_W-1:0]    cntVal,
  input  logic                ovfEvt,
  output logic [BYTE_W-1:0]   rdData,
  output timerCtl_t           ctl,
  output logic [CNT_W-1:0]    cmpVal,
  output logic [BYTE_W-1:0]   ctrlByte
);

  localparam int HI_W = CNT_W - BYTE_W;
  localparam logic [BYTE_W-1:0] KEEP_MASK = ~(BYTE_W'(3) << RSV_LSB);

  logic [BYTE_W-1:0] wrMask;
  logic [BYTE_W-1:0] ctrlQ, ctrlD, ctrlMerged;
  logic [1:0]        modeQ, modeNext;
  logic [CNT_W-1:0]  cmpQ;
  logic [BYTE_W-1:0] cmpLoNext;
  logic [HI_W-1:0]   cmpHiNext;
  logic              ctrlHit, modeHit, loHit, hiHit;

  always_comb begin
    if (!wrEn)      wrMask = '0;
    else if (wrBit) wrMask = BYTE_W'(1) << bitSel;
    else            wrMask = '1;
  end

  assign ctrlHit = wrEn && (addr == A_CTRL);
  assign modeHit = wrEn && (addr == A_MODE);
  assign loHit   = wrEn && (addr == A_CMPLO);
  assign hiHit   = wrEn && (addr == A_CMPHI);

  assign ctrlMerged = (ctrlQ & ~wrMask) | (wrData & wrMask);
  assign modeNext   = (modeQ & ~wrMask[1:0]) | (wrData[1:0] & wrMask[1:0]);
  assign cmpLoNext  = (cmpQ[BYTE_W-1:0] & ~wrMask) | (wrData & wrMask);
  assign cmpHiNext  = (cmpQ[CNT_W-1:BYTE_W] & ~wrMask[HI_W-1:0])
                    | (wrData[HI_W-1:0] & wrMask[HI_W-1:0]);

  // control register next state: unit enable gates everything else
  always_comb begin
    ctrlD = ctrlQ;
    if (!ctrlQ[BIT_UEN]) begin
      ctrlD = '0;
      if (ctrlHit) ctrlD[BIT_UEN] = ctrlMerged[BIT_UEN];
    end else if (ctrlHit && !ctrlMerged[BIT_UEN]) begin
      ctrlD = '0;
    end else begin
      if (ctrlHit) ctrlD = ctrlMerged & KEEP_MASK;
      // a write covering the flag wins over a same-edge overflow
      if (!(ctrlHit && wrMask[BIT_OVF])) ctrlD[BIT_OVF] = ctrlQ[BIT_OVF] | ovfEvt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      modeQ <= '0;
      cmpQ  <= '0;
    end else begin
      ctrlQ <= ctrlD;
      if (modeHit) modeQ <= modeNext;
      if (loHit)   cmpQ[BYTE_W-1:0] <= cmpLoNext;
      if (hiHit)   cmpQ[CNT_W-1:BYTE_W] <= cmpHiNext;
    end
  end

  assign ctl.unitOn     = ctrlQ[BIT_UEN];
  assign ctl.unitClr    = ctrlQ[BIT_UEN] && ctrlHit && !ctrlMerged[BIT_UEN];
  assign ctl.countOn    = ctrlQ[BIT_UEN] && ctrlQ[BIT_CEN];
  assign ctl.clkSel     = ctrlQ[SEL_LSB +: SEL_W];
  assign ctl.clrOnMatch = modeQ[0] && modeQ[1];

  assign cmpVal   = cmpQ;
  assign ctrlByte = ctrlQ;

  always_comb begin
    case (addr)
      A_CTRL:  rdData = ctrlQ;
      A_MODE:  rdData = {{(BYTE_W-2){1'b0}}, modeQ};
      A_CMPLO: rdData = cmpQ[BYTE_W-1:0];
      A_CMPHI: rdData = BYTE_W'(cmpQ[CNT_W-1:BYTE_W]);
      A_CNTLO: rdData = cntVal[BYTE_W-1:0];
      A_CNTHI: rdData = BYTE_W'(cntVal[CNT_W-1:BYTE_W]);
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  timerCtl_t        ctl,
  input  logic [CNT_W-1:0] cmpVal,
  output logic [CNT_W-1:0] cntVal,
  output logic             ovfEvt,
  output logic             ovfIrq
);

  localparam int NUM_DIV = 1 << SEL_W;
  localparam int PRE_W   = NUM_DIV - 1;
  localparam logic [PRE_W-1:0] PRE_ONE = 1;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  logic [PRE_W-1:0]   pre;
  logic [NUM_DIV-1:0] taps;
  logic               tick, step, atMax, match, unitRst;

  assign unitRst = !ctl.unitOn || ctl.unitClr;

  // one tap per divide ratio: tap g fires when the low g prescaler bits are all ones
  for (genvar g = 0; g < NUM_DIV; g++) begin : g_tap
    if (g == 0) begin : g_full
      assign taps[g] = 1'b1;
    end else begin : g_div
      assign taps[g] = &pre[g-1:0];
    end
  end

  assign tick  = taps[ctl.clkSel];
  assign step  = tick && ctl.countOn;
  assign atMax = &cntVal;
  assign match = ctl.clrOnMatch && (cntVal == cmpVal);
  assign ovfEvt = step && atMax && !match;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre    <= '0;
      cntVal <= '0;
      ovfIrq <= 1'b0;
    end else begin
      if (!ctl.countOn || ctl.unitClr) pre <= '0;
      else                             pre <= pre + PRE_ONE;

      if (unitRst)    cntVal <= '0;
      else if (step)  cntVal <= match ? '0 : cntVal + CNT_ONE;

      ovfIrq <= ovfEvt && !ctl.unitClr;
    end
  end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrBit,
  input  logic [2:0]  addr,
  input  logic [2:0]  bitSel,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  output logic        ovfIrq
);

  timerCtl_t        ctl;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] cmpVal;
  logic [7:0]       ctrlByte;
  logic             ovfEvt;

  tick_timer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrBit    (wrBit),
    .addr     (addr),
    .bitSel   (bitSel),
    .wrData   (wrData),
    .cntVal   (cntVal),
    .ovfEvt   (ovfEvt),
    .rdData   (rdData),
    .ctl      (ctl),
    .cmpVal   (cmpVal),
    .ctrlByte (ctrlByte)
  );

  tick_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .cmpVal (cmpVal),
    .cntVal (cntVal),
    .ovfEvt (ovfEvt),
    .ovfIrq (ovfIrq)
  );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [7:0]       ctrlByte,
  input logic             clrOnMatch,
  input logic [CNT_W-1:0] cmpVal,
  input logic [CNT_W-1:0] cntVal,
  input logic             ovfIrq
);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ovfIrq |=> !ovfIrq);

  a_r7_wrapped_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    ovfIrq |-> (cntVal == '0));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctrlByte[3:2] == 2'b00);

  a_r4_held_off: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlByte[0] |-> (cntVal == '0 && ctrlByte == 8'h00));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlByte[7] && !wrEn) |=> ctrlByte[7]);

  a_r6_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlByte[0] && !ctrlByte[1] && !wrEn) |=> $stable(cntVal));

  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (clrOnMatch && cmpVal == '1 && cntVal == '1) |=> !ovfIrq);

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .ctrlByte   (ctrlByte),
  .clrOnMatch (ctl.clrOnMatch),
  .cmpVal     (cmpVal),
  .cntVal     (cntVal),
  .ovfIrq     (ovfIrq)
);

// File: tb/tick_timer_tb.sv
`timescale 1ns/100ps
module tick_timer_tb;
  import tick_timer_pkg::*;

  localparam int CNT_W = 10;
  localparam logic [15:0] CMAX = 16'((1 << CNT_W) - 1);
  localparam int NV = 21;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrBit = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [2:0] bitSel = 3'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       ovfIrq;
  int nErr = 0;
  int nChecks = 0;

  always #2.5 clk = ~clk;

  tick_timer #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBit(wrBit), .addr(addr),
    .bitSel(bitSel), .wrData(wrData), .rdData(rdData), .ovfIrq(ovfIrq)
  );

  // {req, op(0 byte wr, 1 bit wr, 2 read), addr, bitSel, data, expected}
  localparam logic [27:0] VEC [NV] = '{
    {4'd3,  2'd0, 3'd0, 3'd0, 8'hF2, 8'h00},  // R3 write while off
    {4'd3,  2'd2, 3'd0, 3'd0, 8'h00, 8'h00},
    {4'd3,  2'd0, 3'd0, 3'd0, 8'h73, 8'h00},  // R3 only unit enable lands
    {4'd3,  2'd2, 3'd0, 3'd0, 8'h00, 8'h01},
    {4'd2,  2'd0, 3'd0, 3'd0, 8'h5F, 8'h00},  // R2 reserved bits dropped
    {4'd2,  2'd2, 3'd0, 3'd0, 8'h00, 8'h53},
    {4'd13, 2'd1, 3'd0, 3'd1, 8'h00, 8'h00},  // R13 clear count enable alone
    {4'd13, 2'd2, 3'd0, 3'd0, 8'h00, 8'h51},
    {4'd2,  2'd1, 3'd0, 3'd3, 8'h08, 8'h00},  // R2 bit write to reserved bit
    {4'd2,  2'd2, 3'd0, 3'd0, 8'h00, 8'h51},
    {4'd13, 2'd1, 3'd0, 3'd7, 8'h80, 8'h00},  // R13 set flag bit alone
    {4'd13, 2'd2, 3'd0, 3'd0, 8'h00, 8'hD1},
    {4'd8,  2'd1, 3'd0, 3'd7, 8'h00, 8'h00},  // R8 write 0 clears flag
    {4'd8,  2'd2, 3'd0, 3'd0, 8'h00, 8'h51},
    {4'd4,  2'd0, 3'd0, 3'd0, 8'h00, 8'h00},  // R4 unit enable cleared
    {4'd4,  2'd2, 3'd0, 3'd0, 8'h00, 8'h00},
    {4'd4,  2'd2, 3'd4, 3'd0, 8'h00, 8'h00},
    {4'd11, 2'd0, 3'd1, 3'd0, 8'hFF, 8'h00},  // R11 mode keeps two bits
    {4'd11, 2'd2, 3'd1, 3'd0, 8'h00, 8'h03},
    {4'd11, 2'd0, 3'd3, 3'd0, 8'hFF, 8'h00},  // R11 compare high keeps CNT_W-8 bits
    {4'd11, 2'd2, 3'd3, 3'd0, 8'h00, 8'h03}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrB(input logic [2:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrBit = 1'b0; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wrOne(input logic [2:0] a, input logic [2:0] b, input logic [7:0] d);
    addr = a; bitSel = b; wrData = d; wrBit = 1'b1; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrBit = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] v);
    addr = a;
    #0.2;
    v = rdData;
  endtask

  task automatic chkReg(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rdReg(a, v);
    check(tag, {8'h00, v}, {8'h00, exp});
  endtask

  task automatic chkCnt(input string tag, input logic [15:0] exp);
    logic [7:0] lo, hi;
    rdReg(A_CNTLO, lo);
    rdReg(A_CNTHI, hi);
    check(tag, {hi, lo}, exp);
  endtask

  task automatic chkIrq(input string tag, input logic exp);
    check(tag, {15'h0, ovfIrq}, {15'h0, exp});
  endtask

  task automatic restart(input logic [7:0] ctrlVal);
    wrB(A_CTRL, 8'h00);
    wrB(A_CTRL, 8'h01);
    wrB(A_CTRL, ctrlVal);
  endtask

  initial begin
    #1_000_000;
    nErr++; nChecks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    logic [27:0] v;
    logic [7:0]  rv;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chkReg("R1 ctrl", A_CTRL, 8'h00);
    chkReg("R1 mode", A_MODE, 8'h00);
    chkCnt("R1 count", 16'h0);
    chkIrq("R1 irq", 1'b0);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      case (v[23:22])
        2'd0: wrB(v[21:19], v[15:8]);
        2'd1: wrOne(v[21:19], v[18:16], v[15:8]);
        default: begin
          rdReg(v[21:19], rv);
          check($sformatf("R%0d table %0d", v[27:24], i), {8'h00, rv}, {8'h00, v[7:0]});
        end
      endcase
    end

    wrB(A_MODE, 8'h00);
    wrB(A_CMPHI, 8'h00);

    // R5 divide ratios
    for (int k = 0; k < 8; k += (k == 5) ? 2 : ((k == 0) ? 2 : 3)) begin
      restart(8'((k << 4) | 3));
      repeat (300) @(negedge clk);
      chkCnt($sformatf("R5 div code %0d", k), 16'(300 >> k));
    end

    // R6 hold with count enable off
    restart(8'h03);
    repeat (50) @(negedge clk);
    wrB(A_CTRL, 8'h01);
    chkCnt("R6 stop edge", 16'd51);
    repeat (20) @(negedge clk);
    chkCnt("R6 held", 16'd51);

    // R7 overflow, R8 sticky flag, R10 flag writes
    restart(8'h03);
    repeat (int'(CMAX)) @(negedge clk);
    chkCnt("R7 at max", CMAX);
    chkIrq("R7 no early irq", 1'b0);
    @(negedge clk);
    chkIrq("R7 irq", 1'b1);
    chkReg("R7 flag set", A_CTRL, 8'h83);
    chkCnt("R7 wrapped", 16'h0);
    @(negedge clk);
    chkIrq("R7 pulse ends", 1'b0);
    chkReg("R8 flag kept", A_CTRL, 8'h83);
    repeat (10) @(negedge clk);
    chkReg("R8 flag still kept", A_CTRL, 8'h83);
    wrOne(A_CTRL, 3'd7, 8'h00);
    chkReg("R8 flag cleared", A_CTRL, 8'h03);
    chkIrq("R10 clear makes no pulse", 1'b0);
    wrOne(A_CTRL, 3'd7, 8'h80);
    chkIrq("R10 set makes no pulse", 1'b0);
    chkReg("R13 flag set by bit write", A_CTRL, 8'h83);

    // R9 write wins over overflow on the same edge
    restart(8'h03);
    repeat (int'(CMAX)) @(negedge clk);
    chkCnt("R9 at max", CMAX);
    wrB(A_CTRL, 8'h03);
    chkReg("R9 written flag wins", A_CTRL, 8'h03);
    chkIrq("R10 pulse not cancelled", 1'b1);
    chkCnt("R9 wrapped", 16'h0);

    // R4 disable while running
    repeat (20) @(negedge clk);
    wrOne(A_CTRL, 3'd7, 8'h80);
    wrB(A_CTRL, 8'h00);
    chkReg("R4 ctrl cleared", A_CTRL, 8'h00);
    chkCnt("R4 count cleared", 16'h0);
    repeat (5) @(negedge clk);
    wrB(A_CTRL, 8'h01);
    chkCnt("R4 count held", 16'h0);
    chkReg("R4 only unit on", A_CTRL, 8'h01);

    // R11 compare clear
    wrB(A_CMPLO, 8'h05);
    wrB(A_CMPHI, 8'h00);
    wrB(A_MODE, 8'h03);
    restart(8'h03);
    repeat (5) @(negedge clk);
    chkCnt("R11 at compare", 16'd5);
    @(negedge clk);
    chkCnt("R11 cleared", 16'd0);
    repeat (8) @(negedge clk);
    chkCnt("R11 wraps again", 16'd2);
    wrB(A_MODE, 8'h01);
    restart(8'h03);
    repeat (14) @(negedge clk);
    chkCnt("R11 no clear without enable", 16'd14);

    // R12 match at all-ones
    wrB(A_CMPLO, CMAX[7:0]);
    wrB(A_CMPHI, CMAX[15:8]);
    wrB(A_MODE, 8'h03);
    restart(8'h03);
    repeat (int'(CMAX)) @(negedge clk);
    chkCnt("R12 at max", CMAX);
    @(negedge clk);
    chkIrq("R12 no irq", 1'b0);
    chkReg("R12 no flag", A_CTRL, 8'h03);
    chkCnt("R12 cleared", 16'h0);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule